// File: doc/BRIEF.md
# Privilege-Level Interrupt Enable Mask

This block turns the current privilege level, the three per-level global interrupt enable bits and two delegation vectors into a 64-bit enable mask. Downstream logic ANDs the mask with pending and individually enabled interrupts to decide whether anything may be taken. The mask covers nine standard interrupt lines and a 48-bit field of local interrupts in bits 63..16.

Local interrupts are not handled as a separate group that is always on. They follow exactly the rules of the machine-level lines, both for delegation and for privilege masking. Two feature flags describe the core. One says whether a supervisor level exists. The other says whether user-level trap handling exists. Together they decide which delegation vector is honoured.

The mask and an illegal-level flag are registered. Both appear one clock after the inputs are presented.

Top module: `irq_mask_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `irq_mask` becomes all zeros and `bad_mode` becomes 0 after that edge.
- R2: `irq_mask` and `bad_mode` are registered: they reflect the inputs sampled at the previous rising edge and do not change between edges.
- R3: Level encoding: user 2'b00, supervisor 2'b01, machine 2'b11. At machine level with `glb_mie`=1, the mask sets bits 63..16 plus bits 11, 7 and 3. With `glb_mie`=0, the mask is all zeros.
- R4: At machine level, the supervisor bits (9, 5, 1) and the user bits (8, 4, 0) are always 0.
- R5: At supervisor level, each bit of the machine group (63..16, 11, 7, 3) is 1 if its effective machine delegation bit is 0. If that delegation bit is 1, the mask bit equals `glb_sie`.
- R6: At supervisor level, bits 9, 5 and 1 equal `glb_sie`, and bits 8, 4 and 0 are 0.
- R7: At user level with `has_sup`=1, each bit of the machine group and of the supervisor group is 1 if its effective supervisor delegation bit is 0. If that delegation bit is 1, the mask bit equals `glb_uie`.
- R8: At user level with `has_sup`=0, each machine-group bit is 1 if its effective machine delegation bit is 0. If that delegation bit is 1, the mask bit equals `glb_uie`. The supervisor bits are 0.
- R9: At user level, bits 8, 4 and 0 equal `glb_uie`.
- R10: The machine delegation vector counts as zero unless `has_sup` or `has_utrap` is 1. The supervisor delegation vector counts as zero unless both are 1.
- R11: Level 2'b10 gives an all-zero mask with `bad_mode`=1. Every legal level gives `bad_mode`=0.
- R12: Bits 2, 6, 10 and 15..12 of `irq_mask` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 2 | Current privilege level (00 user, 01 supervisor, 11 machine) |
| glb_uie | input | 1 | User-level global interrupt enable |
| glb_sie | input | 1 | Supervisor-level global interrupt enable |
| glb_mie | input | 1 | Machine-level global interrupt enable |
| mach_dlg | input | 64 | Machine-to-lower-level interrupt delegation vector |
| sup_dlg | input | 64 | Supervisor-to-user interrupt delegation vector |
| has_sup | input | 1 | Supervisor level is implemented |
| has_utrap | input | 1 | User-level trap handling is implemented |
| irq_mask | output | 64 | Registered global interrupt enable mask |
| bad_mode | output | 1 | Registered flag for the illegal level encoding |

## Verification
The hardest case to reach is a delegation vector that holds ones but must be ignored because the feature flags disqualify it. No wrong value shows unless the level and enables would otherwise mask the delegated bits. The stimulus therefore drives all-ones delegation vectors with the supervisor or user-trap flag cleared, while the lower-level enable is 0. In that setup every machine-group bit must still come out set. User level without a supervisor level is reached the same way: the supervisor vector is held at all ones to show that it has no effect there.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic [1:0] {
    PM_USER = 2'b00,
    PM_SUPV = 2'b01,
    PM_RSVD = 2'b10,
    PM_MACH = 2'b11
  } priv_e;

  // standard line positions; the mask layout depends on them
  localparam int BIT_USI = 0;
  localparam int BIT_SSI = 1;
  localparam int BIT_MSI = 3;
  localparam int BIT_UTI = 4;
  localparam int BIT_STI = 5;
  localparam int BIT_MTI = 7;
  localparam int BIT_UEI = 8;
  localparam int BIT_SEI = 9;
  localparam int BIT_MEI = 11;

endpackage

// File: rtl/irqm_dlg_qual.sv
module irqm_dlg_qual #(
  parameter int W = 64
) (
  input  logic [W-1:0] mach_dlg_i,
  input  logic [W-1:0] sup_dlg_i,
  input  logic         has_sup_i,
  input  logic         has_utrap_i,
  output logic [W-1:0] mach_dlg_o,
  output logic [W-1:0] sup_dlg_o
);
  logic mach_ok;
  logic sup_ok;

  assign mach_ok    = has_sup_i | has_utrap_i;
  assign sup_ok     = has_sup_i & has_utrap_i;
  assign mach_dlg_o = mach_ok ? mach_dlg_i : '0;
  assign sup_dlg_o  = sup_ok  ? sup_dlg_i  : '0;

  // R10: a delegation vector that is not qualified never reaches the gates
  always_comb begin
    if (!has_sup_i && !has_utrap_i)
      a_mach_zero_r10: assert (mach_dlg_o == '0);
    if (!(has_sup_i && has_utrap_i))
      a_sup_zero_r10: assert (sup_dlg_o == '0);
  end
endmodule

// File: rtl/irqm_dlg_gate.sv
module irqm_dlg_gate #(
  parameter int W = 64
) (
  input  logic [W-1:0] dlg_i,
  input  logic         lvl_en_i,
  output logic [W-1:0] pass_o
);
  // a line passes when it stays at the higher level or the lower level is enabled
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pass_o[i] = ~dlg_i[i] | lvl_en_i;
  end
endmodule

// File: rtl/irq_mask_gen.sv
module irq_mask_gen #(
  parameter int XLEN     = 64,
  parameter int LOCAL_LO = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      priv_mode,
  input  logic            glb_uie,
  input  logic            glb_sie,
  input  logic            glb_mie,
  input  logic [XLEN-1:0] mach_dlg,
  input  logic [XLEN-1:0] sup_dlg,
  input  logic            has_sup,
  input  logic            has_utrap,
  output logic [XLEN-1:0] irq_mask,
  output logic            bad_mode
);
  import irqm_pkg::*;

  localparam int              LOCAL_W = XLEN - LOCAL_LO;
  localparam logic [XLEN-1:0] ONE     = XLEN'(1);
  localparam logic [XLEN-1:0] LOCAL_M = {{LOCAL_W{1'b1}}, {LOCAL_LO{1'b0}}};
  localparam logic [XLEN-1:0] MACH_M  = LOCAL_M | (ONE << BIT_MEI) | (ONE << BIT_MTI) | (ONE << BIT_MSI);
  localparam logic [XLEN-1:0] SUP_M   = (ONE << BIT_SEI) | (ONE << BIT_STI) | (ONE << BIT_SSI);
  localparam logic [XLEN-1:0] USR_M   = (ONE << BIT_UEI) | (ONE << BIT_UTI) | (ONE << BIT_USI);
  localparam logic [XLEN-1:0] RSV_M   = ~(MACH_M | SUP_M | USR_M);

  priv_e           mode;
  logic [XLEN-1:0] mdlg_q, sdlg_q;
  logic [XLEN-1:0] pass_s, pass_us, pass_um;
  logic [XLEN-1:0] mask_nxt;
  logic            bad_nxt;

  assign mode = priv_e'(priv_mode);

  irqm_dlg_qual #(.W(XLEN)) u_qual (
    .mach_dlg_i (mach_dlg),
    .sup_dlg_i  (sup_dlg),
    .has_sup_i  (has_sup),
    .has_utrap_i(has_utrap),
    .mach_dlg_o (mdlg_q),
    .sup_dlg_o  (sdlg_q)
  );

  // supervisor level: lines delegated by machine, opened by the supervisor enable
  irqm_dlg_gate #(.W(XLEN)) u_gate_s (
    .dlg_i(mdlg_q), .lvl_en_i(glb_sie), .pass_o(pass_s)
  );
  // user level, supervisor present: lines delegated by supervisor
  irqm_dlg_gate #(.W(XLEN)) u_gate_us (
    .dlg_i(sdlg_q), .lvl_en_i(glb_uie), .pass_o(pass_us)
  );
  // user level, no supervisor: lines delegated straight from machine
  irqm_dlg_gate #(.W(XLEN)) u_gate_um (
    .dlg_i(mdlg_q), .lvl_en_i(glb_uie), .pass_o(pass_um)
  );

  always_comb begin
    mask_nxt = '0;
    bad_nxt  = 1'b0;
    case (mode)
      PM_MACH: mask_nxt = glb_mie ? MACH_M : '0;
      PM_SUPV: mask_nxt = (MACH_M & pass_s) | (glb_sie ? SUP_M : '0);
      PM_USER: mask_nxt = (has_sup ? ((MACH_M | SUP_M) & pass_us) : (MACH_M & pass_um))
                          | (glb_uie ? USR_M : '0);
      default: bad_nxt  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask <= '0;
      bad_mode <= 1'b0;
    end else begin
      irq_mask <= mask_nxt;
      bad_mode <= bad_nxt;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_mask == '0 && !bad_mode));

  p_mach_off_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_MACH && !glb_mie) |=> irq_mask == '0);

  p_mach_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_MACH) |=> (irq_mask & (SUP_M | USR_M)) == '0);

  p_supv_user_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SUPV) |=> (irq_mask & USR_M) == '0);

  p_user_bits_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_USER && !glb_uie) |=> (irq_mask & USR_M) == '0);

  p_illegal_level_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_RSVD) |=> (bad_mode && irq_mask == '0));

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_mask & RSV_M) == '0);
endmodule

// File: tb/irq_mask_gen_test.sv
`timescale 1ns/1ps
module irq_mask_gen_test;
  localparam int NV = 14;
  localparam logic [63:0] ONES = {64{1'b1}};

  typedef struct packed {
    logic [1:0]  mode;
    logic        uie, sie, mie, hs, hu;
    logic [63:0] md, sd;
  } vec_t;

  // mode, uie, sie, mie, has_sup, has_utrap, machine dlg, supervisor dlg
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, ONES, ONES},                         // R3 R4 on
    '{2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, ONES, ONES},                         // R3 off
    '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'hF0F0_0000_FFFF_0A08, 64'h0},     // R5 sie=0
    '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 64'hF0F0_0000_FFFF_0A08, 64'h0},     // R5 R6 sie=1
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ONES, ONES},                         // R10 machine dlg ignored
    '{2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, ONES, 64'h0F0F_1234_0000_0A2A},      // R7 uie=0
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ONES, 64'h0F0F_1234_0000_0A2A},      // R7 R9 uie=1
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ONES, ONES},                         // R10 sup dlg ignored
    '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h00FF_FF00_5555_0808, ONES},      // R8 uie=0
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h00FF_FF00_5555_0808, ONES},      // R8 R9 uie=1
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ONES, ONES},                         // R10 both ignored
    '{2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, ONES, ONES},                         // R11
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, ONES},                        // R6 no delegation
    '{2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, ONES, 64'h0}                         // R7 nothing delegated
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  priv_mode = 2'b00;
  logic        glb_uie = 1'b0, glb_sie = 1'b0, glb_mie = 1'b0;
  logic [63:0] mach_dlg = '0, sup_dlg = '0;
  logic        has_sup = 1'b0, has_utrap = 1'b0;
  logic [63:0] irq_mask;
  logic        bad_mode;

  int nchk  = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  irq_mask_gen uut (
    .clk(clk), .rst(rst), .priv_mode(priv_mode),
    .glb_uie(glb_uie), .glb_sie(glb_sie), .glb_mie(glb_mie),
    .mach_dlg(mach_dlg), .sup_dlg(sup_dlg),
    .has_sup(has_sup), .has_utrap(has_utrap),
    .irq_mask(irq_mask), .bad_mode(bad_mode)
  );

  // expected mask, written from the requirement text
  function automatic logic [63:0] model(vec_t v);
    logic [63:0] mg, sg, ug, mdq, sdq;
    mg  = {{48{1'b1}}, 16'h0} | 64'h0888;   // local field, bits 11, 7, 3
    sg  = 64'h0222;                          // bits 9, 5, 1
    ug  = 64'h0111;                          // bits 8, 4, 0
    mdq = (v.hs | v.hu) ? v.md : 64'h0;
    sdq = (v.hs & v.hu) ? v.sd : 64'h0;
    case (v.mode)
      2'b11: return v.mie ? mg : 64'h0;
      2'b01: return (mg & (~mdq | {64{v.sie}})) | (v.sie ? sg : 64'h0);
      2'b00: begin
        if (v.hs) return ((mg | sg) & (~sdq | {64{v.uie}})) | (v.uie ? ug : 64'h0);
        else      return (mg & (~mdq | {64{v.uie}})) | (v.uie ? ug : 64'h0);
      end
      default: return 64'h0;
    endcase
  endfunction

  function automatic string req_of(vec_t v);
    if (v.mode == 2'b11) return "R3/R4";
    if (v.mode == 2'b01) return "R5/R6/R10";
    if (v.mode == 2'b10) return "R11";
    return v.hs ? "R7/R9/R10" : "R8/R9/R10";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    priv_mode = v.mode; glb_uie = v.uie; glb_sie = v.sie; glb_mie = v.mie;
    has_sup = v.hs; has_utrap = v.hu; mach_dlg = v.md; sup_dlg = v.sd;
  endtask

  initial begin
    #(20 * 20000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state with machine level fully enabled on the inputs
    drive(VECS[0]);
    repeat (2) @(negedge clk);
    check("R1 mask", irq_mask, 64'h0);
    check("R1 flag", {63'h0, bad_mode}, 64'h0);
    @(negedge clk) rst = 1'b0;

    // table walk: drive at a falling edge, sample one edge later
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check(req_of(VECS[i]), irq_mask, model(VECS[i]));
      check("R11 flag", {63'h0, bad_mode}, {63'h0, VECS[i].mode == 2'b10});
      check("R12 reserved", irq_mask & 64'h0000_0000_0000_F444, 64'h0);
    end

    // R2: output holds until the next rising edge
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[1]);
    #3;
    check("R2 hold", irq_mask, model(VECS[0]));
    @(negedge clk);
    check("R2 update", irq_mask, 64'h0);

    // R11 then back to legal: flag drops
    drive(VECS[11]);
    @(negedge clk);
    check("R11 set", {63'h0, bad_mode}, 64'h1);
    drive(VECS[12]);
    @(negedge clk);
    check("R11 clear", {63'h0, bad_mode}, 64'h0);

    // R1: mid-run reset clears a full mask
    drive(VECS[0]);
    @(negedge clk);
    check("R3 before reset", irq_mask, model(VECS[0]));
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run", irq_mask, 64'h0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule